// File: doc/BRIEF.md
# Random Byte Pool

The block gathers single random bits from an entropy source and assembles them into bytes, first bit in the least significant position. Finished bytes wait in a first-in first-out pool of up to sixteen entries. A requester reaches the pool through a short command interface. Bytes leave on a valid/ready byte stream that stands in for the memory writes a software store would make.

Two request kinds exist. A single store takes the number of whole bytes in the pool at the moment it is accepted. It delivers exactly that many and reports the number in a status field, and that number may be zero. A repeated store asks for a given byte count and does not finish until that many bytes have gone out. It waits for fresh entropy whenever the pool runs dry, and it can be paused by an interrupt-like suspend input. Each request also latches a 2-bit entropy factor. Every factor value gives raw bytes, because whitening is not part of this block.

Top module: `rng_byte_pool`

## Requirements
- R1: After reset, out_valid, busy and done are low, and status, remain and factor are all zero.
- R2: Bits are taken only when ent_valid is high. The first bit of a group lands in bit 0 of the byte and the eighth in bit 7. A byte enters the pool only once its eighth bit has arrived, and the bits of an unfinished byte are kept between requests.
- R3: The pool holds at most 16 bytes. A bit that arrives while 16 bytes are held is dropped and does not count toward the next byte.
- R4: A single store (req_repeat = 0) delivers, oldest first, the number of whole bytes held when it is accepted. It writes that number, 0 to 16, into status[4:0] with every higher status bit zero, and it leaves remain unchanged.
- R5: A single store accepted while no whole byte is held delivers no byte, gives status = 0, and pulses done one cycle after acceptance.
- R6: A repeated store (req_repeat = 1) with req_count > 0 delivers exactly req_count bytes in arrival order and waits for new bytes when the pool is empty. It ends with remain = 0 and leaves status unchanged.
- R7: A repeated store with req_count = 0 pulses done one cycle after acceptance, delivers nothing, and leaves status, remain and factor unchanged.
- R8: Every other request sets factor to factor_in[1:0] with all higher bits zero. The factor value has no effect on the byte values delivered.
- R9: While suspend is high during a repeated store, no byte is offered and remain holds its value. After suspend falls the store continues, and the total delivered equals the original req_count.
- R10: While out_valid is high and out_ready is low, out_data holds its value. At most one byte moves per cycle.
- R11: done is high for the one cycle that follows the final byte transfer of a request, and busy is low in that cycle. A request is accepted only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_valid | input | 1 | Entropy bit strobe |
| ent_bit | input | 1 | Entropy bit value |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_repeat | input | 1 | 0 = single store, 1 = repeated store |
| req_count | input | REQ_W | Byte count for a repeated store |
| factor_in | input | FACTOR_W | Entropy factor supplied with the request |
| suspend | input | 1 | Pauses a repeated store |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | STAT_W | Byte count of the last single store in bits 4:0 |
| remain | output | REQ_W | Bytes still owed by a repeated store |
| factor | output | FACTOR_W | Latched entropy factor |
| out_valid | output | 1 | A byte is offered |
| out_data | output | 8 | Offered byte |
| out_ready | input | 1 | Consumer takes the offered byte |

## Verification
A byte can finish packing and enter the pool on the same clock edge that the consumer takes the oldest byte out, so a push and a pop coincide. The bench provokes this by streaming one entropy bit per cycle while a repeated store drains the pool, with out_ready both steady and toggling. A bench-side model of the packer and pool judges each transferred byte. The order of the bytes, their values, the total count and the final remain value must all match a pool that neither loses nor duplicates an entry when both actions land together.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} rbp_state_e;
  localparam int unsigned COUNT_FIELD_W = 5;
  localparam int unsigned FACTOR_KEEP_W = 2;
endpackage

// File: rtl/rbp_packer.sv
module rbp_packer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              accept,
  output logic              push,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc_q, acc_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              take;

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    push  = 1'b0;
    take  = bit_vld && accept;
    if (take) begin
      acc_d[idx_q] = bit_in;
      if (idx_q == LAST_IDX) begin
        push  = 1'b1;
        idx_d = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
    byte_out = acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  // R2: the bit index only moves when a bit was taken
  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_vld && accept) |=> $stable(idx_q));
endmodule

// File: rtl/rbp_fifo.sv
module rbp_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_W'(1);
    if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + PTR_W'(1);
    if (push && !pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wptr_q == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) mem[gi] <= wdata;
    end
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_FULL);
  assign empty = (cnt_q == '0);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(rdata));
endmodule

// File: rtl/rbp_ctrl.sv
module rbp_ctrl
  import rbp_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned REQ_W    = 16,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned FACTOR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_repeat,
  input  logic [REQ_W-1:0]           req_count,
  input  logic [FACTOR_W-1:0]        factor_in,
  input  logic                       suspend,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input  logic                       fifo_empty,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic                       pop,
  output logic                       busy,
  output logic                       done,
  output logic [STAT_W-1:0]          status,
  output logic [REQ_W-1:0]           remain,
  output logic [FACTOR_W-1:0]        factor
);
  rbp_state_e          state_q, state_d;
  logic                rep_q, rep_d;
  logic [REQ_W-1:0]    todo_q, todo_d;
  logic [REQ_W-1:0]    remain_q, remain_d;
  logic [STAT_W-1:0]   status_q, status_d;
  logic [FACTOR_W-1:0] factor_q, factor_d;
  logic                done_q, done_d;
  logic [FACTOR_W-1:0] factor_kept;

  assign factor_kept = {{(FACTOR_W-FACTOR_KEEP_W){1'b0}}, factor_in[FACTOR_KEEP_W-1:0]};

  always_comb begin
    state_d  = state_q;
    rep_d    = rep_q;
    todo_d   = todo_q;
    remain_d = remain_q;
    status_d = status_q;
    factor_d = factor_q;
    done_d   = 1'b0;
    out_valid = (state_q == ST_RUN) && !fifo_empty && !(rep_q && suspend);
    pop       = out_valid && out_ready;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          rep_d = req_repeat;
          if (req_repeat) begin
            if (req_count == '0) begin
              done_d = 1'b1;
            end else begin
              todo_d   = req_count;
              remain_d = req_count;
              factor_d = factor_kept;
              state_d  = ST_RUN;
            end
          end else begin
            status_d = STAT_W'(fifo_count);
            factor_d = factor_kept;
            if (fifo_count == '0) begin
              done_d = 1'b1;
            end else begin
              todo_d  = REQ_W'(fifo_count);
              state_d = ST_RUN;
            end
          end
        end
      end
      ST_RUN: begin
        if (pop) begin
          todo_d = todo_q - REQ_W'(1);
          if (rep_q) remain_d = remain_q - REQ_W'(1);
          if (todo_q == REQ_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rep_q    <= 1'b0;
      todo_q   <= '0;
      remain_q <= '0;
      status_q <= '0;
      factor_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rep_q    <= rep_d;
      todo_q   <= todo_d;
      remain_q <= remain_d;
      status_q <= status_d;
      factor_q <= factor_d;
      done_q   <= done_d;
    end
  end

  assign busy   = (state_q == ST_RUN);
  assign done   = done_q;
  assign status = status_q;
  assign remain = remain_q;
  assign factor = factor_q;

  a_r4_status_range: assert property (@(posedge clk) disable iff (!rst_n)
    status_q <= STAT_W'(DEPTH));
  a_r6_remain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_q && pop) |=> (remain_q == $past(remain_q) - REQ_W'(1)));
  a_r9_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rep_q && suspend) |=> ($stable(remain_q) && $stable(todo_q)));
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
endmodule

// File: rtl/rng_byte_pool.sv
module rng_byte_pool #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned REQ_W    = 16,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned FACTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ent_valid,
  input  logic                ent_bit,
  input  logic                req_valid,
  input  logic                req_repeat,
  input  logic [REQ_W-1:0]    req_count,
  input  logic [FACTOR_W-1:0] factor_in,
  input  logic                suspend,
  output logic                busy,
  output logic                done,
  output logic [STAT_W-1:0]   status,
  output logic [REQ_W-1:0]    remain,
  output logic [FACTOR_W-1:0] factor,
  output logic                out_valid,
  output logic [7:0]          out_data,
  input  logic                out_ready
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              push, pop, full, empty;
  logic [BYTE_W-1:0] packed_byte;
  logic [CNT_W-1:0]  fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rbp_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .bit_vld  (ent_valid),
    .bit_in   (ent_bit),
    .accept   (!full),
    .push     (push),
    .byte_out (packed_byte)
  );

  rbp_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (push),
    .wdata (packed_byte),
    .pop   (pop),
    .rdata (out_data),
    .count (fill),
    .full  (full),
    .empty (empty)
  );

  rbp_ctrl #(.DEPTH(DEPTH), .REQ_W(REQ_W), .STAT_W(STAT_W), .FACTOR_W(FACTOR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_repeat (req_repeat),
    .req_count  (req_count),
    .factor_in  (factor_in),
    .suspend    (suspend),
    .fifo_count (fill),
    .fifo_empty (empty),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .pop        (pop),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .remain     (remain),
    .factor     (factor)
  );
endmodule

// File: tb/rng_byte_pool_bench.sv
module rng_byte_pool_bench;
  localparam int DEPTH = 16;
  localparam int REQ_W = 16;
  localparam int STAT_W = 8;
  localparam int FW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ent_valid, ent_bit, req_valid, req_repeat, suspend, out_ready;
  logic [REQ_W-1:0] req_count;
  logic [FW-1:0] factor_in;
  logic busy, done, out_valid;
  logic [STAT_W-1:0] status;
  logic [REQ_W-1:0] remain;
  logic [FW-1:0] factor;
  logic [7:0] out_data;

  rng_byte_pool u_rng_byte_pool (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_bit(ent_bit),
    .req_valid(req_valid), .req_repeat(req_repeat), .req_count(req_count),
    .factor_in(factor_in), .suspend(suspend), .busy(busy), .done(done),
    .status(status), .remain(remain), .factor(factor), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] model_q[$];
  logic [7:0] part = 8'h00;
  int nbits = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [STAT_W-1:0] last_status = '0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R6 watchdog act=%0d exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    ent_valid = 1'b1;
    ent_bit   = b;
    if (model_q.size() < DEPTH) begin
      part[nbits] = b;
      nbits++;
      if (nbits == 8) begin
        model_q.push_back(part);
        nbits = 0;
        part  = 8'h00;
      end
    end
  endtask

  function automatic logic rand_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic feed_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      drive_bit(v[i]);
      tick();
    end
    ent_valid = 1'b0;
  endtask

  task automatic run_req(input logic rep, input logic [REQ_W-1:0] cnt, input logic [FW-1:0] fac,
                         input logic [7:0] rpat, input logic feed, input int s_lo, input int s_hi,
                         input string tag, output int got, output int lat);
    logic prev_stall;
    logic [7:0] prev_data;
    logic [7:0] exp;
    int k;
    req_valid = 1'b1; req_repeat = rep; req_count = cnt; factor_in = fac;
    tick();
    req_valid = 1'b0;
    got = 0; k = 0; prev_stall = 1'b0; prev_data = 8'h00; lat = -1;
    while (k < 3000) begin
      if (done) begin
        lat = k;
        break;
      end
      suspend   = (k >= s_lo) && (k < s_hi);
      out_ready = rpat[k % 8];
      #1;
      if (suspend && rep) chk("R9 no offer while suspended", out_valid, 1'b0);
      if (prev_stall && out_valid) chk("R10 data held under backpressure", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (model_q.size() == 0) begin
          chk({tag, " unexpected byte"}, 1, 0);
        end else begin
          exp = model_q.pop_front();
          chk(tag, out_data, exp);
        end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (feed) drive_bit(rand_bit());
      else ent_valid = 1'b0;
      tick();
      k++;
    end
    ent_valid = 1'b0; out_ready = 1'b0; suspend = 1'b0;
    #1;
    chk("R11 busy low with done", busy, 1'b0);
    tick();
    chk("R11 done is one cycle", done, 1'b0);
  endtask

  task automatic flush();
    int g, l;
    if (nbits != 0) begin
      for (int i = nbits; i < 8; i++) begin
        drive_bit(1'b0);
        tick();
      end
      ent_valid = 1'b0;
    end
    run_req(1'b0, '0, 8'h00, 8'hFF, 1'b0, 0, 0, "R4 flush byte", g, l);
    last_status = status;
  endtask

  initial begin
    int got, lat;
    logic [STAT_W-1:0] s0;
    logic [REQ_W-1:0] r0;
    logic [FW-1:0] f0;
    rst_n = 1'b0; ent_valid = 1'b0; ent_bit = 1'b0; req_valid = 1'b0; req_repeat = 1'b0;
    req_count = '0; factor_in = '0; suspend = 1'b0; out_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 status", status, 0);
    chk("R1 remain", remain, 0);
    chk("R1 factor", factor, 0);

    // R5 and R2: five bits of 0xA5 only, no whole byte
    for (int i = 0; i < 5; i++) begin
      drive_bit(1'(8'hA5 >> i));
      tick();
    end
    ent_valid = 1'b0;
    run_req(1'b0, '0, 8'h01, 8'hFF, 1'b0, 0, 0, "R5 single empty", got, lat);
    chk("R5 no bytes", got, 0);
    chk("R5 status zero", status, 0);
    chk("R5 done one cycle after accept", lat, 0);
    last_status = status;

    // R2 partial kept: finish 0xA5, add three bytes, LSB-first packing
    for (int i = 5; i < 8; i++) begin
      drive_bit(1'(8'hA5 >> i));
      tick();
    end
    ent_valid = 1'b0;
    feed_byte(8'h01); feed_byte(8'h80); feed_byte(8'h3E);
    run_req(1'b0, '0, 8'h02, 8'hFF, 1'b0, 0, 0, "R2 LSB-first byte", got, lat);
    chk("R4 four bytes", got, 4);
    chk("R4 status four", status, 4);
    chk("R4 remain unchanged", remain, 0);
    last_status = status;

    // R3 overfill: 20 bytes offered, 16 kept, dropped bits leave no partial
    for (int b = 0; b < 20; b++) feed_byte(8'(b * 37 + 11));
    run_req(1'b0, '0, 8'h03, 8'hFF, 1'b0, 0, 0, "R3 kept byte", got, lat);
    chk("R3 sixteen bytes", got, 16);
    chk("R3 status sixteen", status, 16);
    feed_byte(8'h3C);
    run_req(1'b0, '0, 8'h00, 8'hFF, 1'b0, 0, 0, "R3 byte after overflow", got, lat);
    chk("R3 one byte after drop", got, 1);
    chk("R3 status one", status, 1);
    last_status = status;

    // R10 backpressure with a toggling ready
    for (int b = 0; b < 6; b++) feed_byte(8'(8'hC3 ^ (b * 17)));
    run_req(1'b0, '0, 8'h00, 8'b1001_0110, 1'b0, 0, 0, "R10 byte under stall", got, lat);
    chk("R10 six bytes", got, 6);
    chk("R10 status six", status, 6);
    last_status = status;

    // R6/R8: repeated store from empty pool, bits stream while draining (push and pop together)
    run_req(1'b1, 16'd12, 8'hAE, 8'b1101_1011, 1'b1, 0, 0, "R6 repeated byte", got, lat);
    chk("R6 exact count", got, 12);
    chk("R6 remain zero", remain, 0);
    chk("R6 status unchanged", status, last_status);
    chk("R8 factor low bits only", factor, 8'h02);
    flush();
    run_req(1'b1, 16'd9, 8'h01, 8'hFF, 1'b1, 0, 0, "R6 repeated ready steady", got, lat);
    chk("R6 exact count steady", got, 9);
    chk("R8 factor one", factor, 8'h01);
    flush();

    // R7 zero-count repeated store
    s0 = status; r0 = remain; f0 = factor;
    run_req(1'b1, 16'd0, 8'hFF, 8'hFF, 1'b0, 0, 0, "R7 zero count", got, lat);
    chk("R7 no bytes", got, 0);
    chk("R7 done next cycle", lat, 0);
    chk("R7 status kept", status, s0);
    chk("R7 remain kept", remain, r0);
    chk("R7 factor kept", factor, f0);

    // R9 suspend and resume
    for (int b = 0; b < 16; b++) feed_byte(8'(b * 29 + 5));
    run_req(1'b1, 16'd10, 8'h03, 8'hFF, 1'b0, 2, 7, "R9 byte around suspend", got, lat);
    chk("R9 total equals request", got, 10);
    chk("R9 remain zero", remain, 0);
    flush();

    // R4/R8 sweep over every pool fill level and every factor value
    for (int n = 0; n <= DEPTH; n++) begin
      for (int b = 0; b < n; b++) feed_byte(8'((n * 13 + b) ^ 8'h5A));
      run_req(1'b0, '0, 8'(8'hF0 | (n % 4)), 8'b0111_1110, 1'b0, 0, 0, "R8 raw byte any factor", got, lat);
      chk("R4 sweep count", got, n);
      chk("R4 sweep status", status, n);
      chk("R8 sweep factor", factor, n % 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule